// File: doc/BRIEF.md
# I2C Slave Receiver with Double-Buffered Receive Byte

This block is the receive side of an I2C target. It watches the SCL and SDA lines, finds START, repeated START and STOP conditions, and compares a 7-bit address. Once the address matches with the write direction, it collects data bytes. Each finished byte passes from a bit shift register into a separate one-byte holding buffer, so the next byte can arrive on the bus while the host has not yet read the previous one. It acknowledges each byte when the byte enters the holding buffer and raises a ready flag. A host read clears that flag, and the flag can drive an interrupt or a DMA request.

A host read can arrive at any time. It never changes the bus state machine, so the read may land during any bit of the next byte, including the seventh. If a new byte is complete while the holding buffer is still full, the block keeps SCL low before the acknowledge clock. It releases SCL only after the host has read the buffer. The block then moves the new byte in and acknowledges it. SCL and SDA are driven as open-drain pull-down enables. A status output shows when the synchronised SCL level is low.

Top module: `i2c_slave_rx_dbuf`

## Requirements
- R1: While reset is held, and on the first cycle after it, sda_oe, scl_oe, rx_ready and overrun are all 0.
- R2: The first byte after a START or repeated START is taken as 7 address bits, MSB first, followed by a direction bit (0 = write). The block drives SDA low in the ninth clock only if the address equals SLAVE_ADDR and the direction bit is 0. Otherwise it leaves SDA released (NACK) and ignores the bus until the next START.
- R3: After an accepted address, each data byte is shifted in MSB first, appears on rx_data and sets rx_ready, and receives an ACK in its ninth clock.
- R4: A one-cycle rd_strobe clears rx_ready on the next clock edge and leaves rx_data unchanged.
- R5: The next byte can be received while rx_ready is still 1. A rd_strobe at any point during that byte, including its seventh bit, causes no SCL stretch, no abort and no lost ACK, and the new byte is delivered.
- R6: If a byte has finished shifting while rx_ready is still 1, the block holds SCL low (scl_oe = 1) after the eighth SCL fall. rx_data keeps the old byte until the host read. After the read, the block delivers the new byte, acknowledges it and releases SCL.
- R7: scl_low equals the inverted SCL line level as seen two clock edges earlier (after the SYNC_STAGES flip-flops). It therefore reads 1 throughout a stretch.
- R8: A repeated START in the middle of a data byte discards the partly received bits and restarts address reception.
- R9: A STOP returns the block to idle with both enables released. Bytes clocked after a STOP without a new START get a NACK and do not set rx_ready.
- R10: overrun becomes 1 when a STOP arrives after all eight bits of a data byte have been sampled but while rx_ready is still 1. That byte is dropped, and rx_data keeps the buffered byte. overrun returns to 0 at the next START.
- R11: sda_oe never changes while the synchronised SCL level is high, so the block itself never creates a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| rd_strobe | input | 1 | One-cycle host read of the receive buffer |
| rx_data | output | DATA_W | Receive buffer contents |
| rx_ready | output | 1 | Receive buffer holds an unread byte |
| scl_low | output | 1 | Synchronised SCL level is low |
| overrun | output | 1 | A complete byte was lost at a STOP |

## Verification
The hardest cases to reach are those where the host read lands in a particular bit of the following byte. These are a read inside the seventh bit, and no read at all until the block has stretched SCL. The bench runs the bus master and the host in two parallel branches. The host branch counts rising SCL edges on the resolved line and pulses the read two cycles into the seventh high phase. For the stretch case, the host branch instead waits for scl_oe and reads only after the master has been stalled for a while. A third stimulus stops the master right after the eighth data bit's high phase, with the buffer full, to provoke the overrun.

// File: rtl/i2c_slave_rx_pkg.sv
package i2c_slave_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_HOLD,
    ST_SETUP,
    ST_DATA_ACK
  } rx_state_t;

  typedef struct packed {
    logic scl_hi;
    logic sda_hi;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_slave_rx_linesync.sv
module i2c_slave_rx_linesync
  import i2c_slave_rx_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_in,
  input  logic    sda_in,
  output bus_ev_t ev
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  // first stage takes the pin, later stages are generated
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q[0] <= 1'b1;
      sda_q[0] <= 1'b1;
    end else begin
      scl_q[0] <= scl_in;
      sda_q[0] <= sda_in;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        scl_q[g] <= 1'b1;
        sda_q[g] <= 1'b1;
      end else begin
        scl_q[g] <= scl_q[g-1];
        sda_q[g] <= sda_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_q[LAST];
      sda_d <= sda_q[LAST];
    end
  end

  always_comb begin
    ev.scl_hi   = scl_q[LAST];
    ev.sda_hi   = sda_q[LAST];
    ev.scl_rise = scl_q[LAST] & ~scl_d;
    ev.scl_fall = ~scl_q[LAST] & scl_d;
    ev.start    = scl_q[LAST] & scl_d & sda_d & ~sda_q[LAST];
    ev.stop     = scl_q[LAST] & scl_d & ~sda_d & sda_q[LAST];
  end

endmodule

// File: rtl/i2c_slave_rx_buffer.sv
module i2c_slave_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] dout,
  output logic         full
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      full <= 1'b0;
    end else begin
      if (load) begin
        dout <= din;
        full <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/i2c_slave_rx_ctrl.sv
module i2c_slave_rx_ctrl
  import i2c_slave_rx_pkg::*;
#(
  parameter int          DW        = 8,
  parameter int          AW        = 7,
  parameter logic [AW-1:0] MY_ADDR = '0,
  parameter int          SETUP_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_ev_t       ev,
  input  logic          buf_full,
  output logic          buf_load,
  output logic [DW-1:0] shreg,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          overrun,
  output rx_state_t     state
);

  localparam int CW = $clog2(DW + 1);
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam logic [CW-1:0] ADDR_BITS = CW'(AW + 1);
  localparam logic [CW-1:0] DATA_BITS = CW'(DW);
  localparam logic [SW-1:0] SETUP_END = SW'(SETUP_CYC - 1);

  logic [CW-1:0] bit_cnt;
  logic [SW-1:0] setup_cnt;
  logic          addr_hit;

  assign addr_hit = (shreg[AW:1] == MY_ADDR) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      setup_cnt <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      overrun   <= 1'b0;
      buf_load  <= 1'b0;
    end else begin
      buf_load <= 1'b0;
      if (ev.start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
        scl_oe  <= 1'b0;
        overrun <= 1'b0;
      end else if (ev.stop) begin
        if (state == ST_DATA && bit_cnt == DATA_BITS && buf_full)
          overrun <= 1'b1;
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (ev.scl_rise && bit_cnt < ADDR_BITS) begin
              shreg   <= {shreg[DW-2:0], ev.sda_hi};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall && bit_cnt == ADDR_BITS) begin
              if (addr_hit) begin
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (ev.scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (ev.scl_rise && bit_cnt < DATA_BITS) begin
              shreg   <= {shreg[DW-2:0], ev.sda_hi};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (ev.scl_fall && bit_cnt == DATA_BITS) begin
              if (buf_full) begin
                scl_oe <= 1'b1;
                state  <= ST_HOLD;
              end else begin
                buf_load <= 1'b1;
                sda_oe   <= 1'b1;
                state    <= ST_DATA_ACK;
              end
            end
          end
          ST_HOLD: begin
            if (!buf_full) begin
              buf_load  <= 1'b1;
              sda_oe    <= 1'b1;
              setup_cnt <= '0;
              state     <= ST_SETUP;
            end
          end
          ST_SETUP: begin
            if (setup_cnt == SETUP_END) begin
              scl_oe <= 1'b0;
              state  <= ST_DATA_ACK;
            end else begin
              setup_cnt <= setup_cnt + 1'b1;
            end
          end
          ST_DATA_ACK: begin
            if (ev.scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_DATA;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_slave_rx_dbuf.sv
module i2c_slave_rx_dbuf
  import i2c_slave_rx_pkg::*;
#(
  parameter int              DATA_W      = 8,
  parameter int              ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h52,
  parameter int              SYNC_STAGES = 2,
  parameter int              SETUP_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              scl_low,
  output logic              overrun
);

  bus_ev_t           ev;
  rx_state_t         state;
  logic              buf_load;
  logic [DATA_W-1:0] shreg;
  logic              scl_lvl;
  logic              stop_det;
  logic              in_idle;

  i2c_slave_rx_linesync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .scl_in (scl_in),
    .sda_in (sda_in),
    .ev     (ev)
  );

  i2c_slave_rx_ctrl #(
    .DW        (DATA_W),
    .AW        (ADDR_W),
    .MY_ADDR   (SLAVE_ADDR),
    .SETUP_CYC (SETUP_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .buf_full (rx_ready),
    .buf_load (buf_load),
    .shreg    (shreg),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .overrun  (overrun),
    .state    (state)
  );

  i2c_slave_rx_buffer #(
    .W (DATA_W)
  ) u_buf (
    .clk  (clk),
    .rst  (rst),
    .load (buf_load),
    .din  (shreg),
    .rd   (rd_strobe),
    .dout (rx_data),
    .full (rx_ready)
  );

  assign scl_lvl  = ev.scl_hi;
  assign scl_low  = ~ev.scl_hi;
  assign stop_det = ev.stop;
  assign in_idle  = (state == ST_IDLE);

endmodule

// File: rtl/i2c_slave_rx_dbuf_chk.sv
module i2c_slave_rx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic scl_lvl,
  input logic sda_oe,
  input logic scl_oe,
  input logic rx_ready,
  input logic rd_strobe,
  input logic buf_load,
  input logic overrun,
  input logic stop_det,
  input logic in_idle
);

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    scl_lvl && $past(scl_lvl) |-> $stable(sda_oe)); // R11

  AST_STRETCH_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> $past(rx_ready)); // R6

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !buf_load |=> !rx_ready); // R4

  AST_OVR_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(stop_det)); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    in_idle |-> !scl_oe && !sda_oe); // R9

endmodule

bind i2c_slave_rx_dbuf i2c_slave_rx_dbuf_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_lvl   (scl_lvl),
  .sda_oe    (sda_oe),
  .scl_oe    (scl_oe),
  .rx_ready  (rx_ready),
  .rd_strobe (rd_strobe),
  .buf_load  (buf_load),
  .overrun   (overrun),
  .stop_det  (stop_det),
  .in_idle   (in_idle)
);

// File: tb/i2c_slave_rx_dbuf_tb.sv
`timescale 1ns/1ps
module i2c_slave_rx_dbuf_tb;

  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h52;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       rd_strobe = 1'b0;
  logic       scl_oe, sda_oe, rx_ready, scl_low, overrun;
  logic [7:0] rx_data;
  wire        scl_line = scl_m & ~scl_oe;
  wire        sda_line = sda_m & ~sda_oe;

  int vec = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  bit stretch_seen = 1'b0;

  always #10 clk = ~clk;

  i2c_slave_rx_dbuf u_dut (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_line),
    .sda_in    (sda_line),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .rd_strobe (rd_strobe),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .scl_low   (scl_low),
    .overrun   (overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference: SCL status delay line and SDA quiet rule
  logic [1:0] scl_hist = 2'b11;
  logic       prev_line = 1'b1;
  logic       prev_sda_oe = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      chk(scl_low == !scl_hist[1], "R7 scl_low", int'(scl_low), int'(!scl_hist[1]));
      if (scl_line && prev_line)
        chk(sda_oe == prev_sda_oe, "R11 sda_oe moved with SCL high", int'(sda_oe), int'(prev_sda_oe));
      if (scl_oe) stretch_seen = 1'b1;
    end
    scl_hist  = {scl_hist[0], scl_line};
    prev_line = scl_line;
    prev_sda_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1;
    while (!scl_line) tick(1);
    tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bus_bit(input logic b, output logic smp);
    sda_m = b; tick(Q);
    scl_m = 1'b1;
    while (!scl_line) tick(1);
    tick(Q);
    smp = sda_line;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic host_read(input string req);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk(rx_ready == 1'b1, req, int'(rx_ready), 1);
    chk(rx_data == e, req, int'(rx_data), int'(e));
    rd_strobe = 1'b1; tick(1);
    rd_strobe = 1'b0;
    chk(rx_ready == 1'b0, "R4 ready cleared by read", int'(rx_ready), 0);
    chk(rx_data == e, "R4 data kept after read", int'(rx_data), int'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic s;

    // R1 reset
    tick(5);
    chk({sda_oe, scl_oe, rx_ready, overrun} == 4'b0, "R1 outputs in reset",
        int'({sda_oe, scl_oe, rx_ready, overrun}), 0);
    rst = 1'b0; tick(1);
    chk({sda_oe, scl_oe, rx_ready, overrun} == 4'b0, "R1 outputs after reset",
        int'({sda_oe, scl_oe, rx_ready, overrun}), 0);
    tick(Q);

    // R2 wrong address, then data ignored
    bus_start();
    bus_byte({7'h13, 1'b0}, ack);
    chk(!ack, "R2 NACK on address mismatch", int'(ack), 0);
    bus_byte(8'hAA, ack);
    chk(!ack, "R2 data after mismatch not acked", int'(ack), 0);
    chk(!rx_ready, "R2 no ready after mismatch", int'(rx_ready), 0);
    bus_stop();

    // R2 read direction refused
    bus_start();
    bus_byte({MY_ADDR, 1'b1}, ack);
    chk(!ack, "R2 NACK on read direction", int'(ack), 0);
    bus_stop();

    // R3 / R4 normal write
    bus_start();
    bus_byte({MY_ADDR, 1'b0}, ack);
    chk(ack, "R2 ACK on matching write", int'(ack), 1);
    bus_byte(8'hC5, ack); exp_q.push_back(8'hC5);
    chk(ack, "R3 data byte acked", int'(ack), 1);
    host_read("R3 byte C5 delivered");
    bus_byte(8'h3A, ack); exp_q.push_back(8'h3A);
    chk(ack, "R3 second byte acked", int'(ack), 1);
    host_read("R3 byte 3A delivered");
    bus_stop();
    chk(!overrun, "R10 no overrun on clean stop", int'(overrun), 0);

    // R9 bits after STOP without START
    scl_m = 1'b0; tick(Q);
    bus_byte(8'h77, ack);
    chk(!ack, "R9 NACK without START", int'(ack), 0);
    chk(!rx_ready, "R9 no ready without START", int'(rx_ready), 0);

    // R5 read in 7th bit of the next byte
    bus_start();
    bus_byte({MY_ADDR, 1'b0}, ack);
    bus_byte(8'h96, ack); exp_q.push_back(8'h96);
    stretch_seen = 1'b0;
    fork
      begin
        bus_byte(8'h5B, ack);
      end
      begin
        repeat (7) @(posedge scl_line);
        tick(2);
        host_read("R5 old byte held during next byte");
      end
    join
    exp_q.push_back(8'h5B);
    chk(ack, "R5 byte acked after 7th-bit read", int'(ack), 1);
    chk(!stretch_seen, "R5 no stretch on timely read", int'(stretch_seen), 0);
    host_read("R5 byte 5B delivered");

    // R6 / R7 stretch with full buffer
    bus_byte(8'hE1, ack); exp_q.push_back(8'hE1);
    fork
      begin
        bus_byte(8'h0F, ack);
      end
      begin
        wait (scl_oe);
        tick(30);
        chk(scl_oe, "R6 SCL held while full", int'(scl_oe), 1);
        chk(scl_low, "R7 scl_low during stretch", int'(scl_low), 1);
        host_read("R6 old byte until read");
      end
    join
    exp_q.push_back(8'h0F);
    chk(ack, "R6 held byte acked after read", int'(ack), 1);
    chk(!scl_oe, "R6 SCL released", int'(scl_oe), 0);
    host_read("R6 byte 0F delivered");
    bus_stop();

    // R8 repeated START mid-byte
    bus_start();
    bus_byte({MY_ADDR, 1'b0}, ack);
    bus_bit(1'b1, s); bus_bit(1'b0, s); bus_bit(1'b1, s);
    bus_start();
    bus_byte({MY_ADDR, 1'b0}, ack);
    chk(ack, "R8 address acked after repeated START", int'(ack), 1);
    bus_byte(8'h6C, ack); exp_q.push_back(8'h6C);
    chk(ack, "R8 byte acked", int'(ack), 1);
    host_read("R8 byte 6C delivered");
    bus_stop();

    // R10 overrun
    bus_start();
    bus_byte({MY_ADDR, 1'b0}, ack);
    bus_byte(8'h81, ack); exp_q.push_back(8'h81);
    for (int i = 7; i >= 1; i--) bus_bit(1'(8'hA4 >> i), s);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
    chk(overrun, "R10 overrun on STOP with pending byte", int'(overrun), 1);
    chk(rx_data == 8'h81, "R10 buffer kept", int'(rx_data), 'h81);
    chk(!scl_oe && !sda_oe, "R9 released after STOP", int'({scl_oe, sda_oe}), 0);
    bus_start();
    chk(!overrun, "R10 overrun cleared by START", int'(overrun), 0);
    bus_stop();
    host_read("R10 buffered byte still readable");

    tick(Q);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule